// File: doc/BRIEF.md
# Instruction Control Decoder

A purely combinational block that looks at a 32-bit RISC-V instruction word and produces the control lines a single-cycle datapath needs. It cuts the word into its major opcode, its 3-bit function field and its 7-bit function field. It then compares these fields against the encoding of each supported instruction, which gives one match line per instruction.

A priority stage turns the match lines into a compact instruction number and a valid flag. The number addresses a small constant control table. The packed word read from the table is split into a register-write enable, a 3-bit ALU operation code, an ALU second-operand source select and a write-back source select.

The block recognises four instructions: immediate add, register add, register subtract and word load. Any other word reads as unrecognised, and the block then drives every control line low, so nothing is written.

Top module: `inst_ctrl_decoder`

## Requirements
- R1: A word with bits 6..0 = 0010011 and bits 14..12 = 000 decodes as immediate add for any value of bits 31..25. It gives number 0, valid 1 and control word 6'b010001.
- R2: A word with bits 6..0 = 0110011, bits 14..12 = 000 and bits 31..25 = 0000000 decodes as register add. It gives number 1, valid 1 and control word 6'b010000.
- R3: The same opcode and bits 14..12 with bits 31..25 = 0100000 decode as subtract. They give number 2, valid 1 and control word 6'b010010.
- R4: A word with bits 6..0 = 0000011 and bits 14..12 = 010 decodes as word load. It gives number 3, valid 1 and control word 6'b110001. The write-back source select (bit 5) is high for this instruction only.
- R5: Any word that matches no supported encoding gives valid 0, number 0 and an all-zero control word.
- R6: A register-format word (opcode 0110011) whose bits 31..25 are neither 0000000 nor 0100000, or whose bits 14..12 are not 000, is unrecognised.
- R7: The control word is packed as bit 5 = write-back source (1 = memory data), bit 4 = register write, bits 3..1 = ALU operation (000 add, 001 subtract) and bit 0 = B source (1 = immediate). Each output port carries exactly its field.
- R8: The word 0x00B50633 decodes as register add with control 6'b010000. The word 0x00100513 decodes as immediate add with control 6'b010001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| inst_num_o | output | 3 | Instruction number of the matched instruction, 0 when unrecognised |
| inst_valid_o | output | 1 | High when a supported instruction matched |
| ctrl_word_o | output | 6 | Packed control word |
| reg_wr_o | output | 1 | Register file write enable |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU B operand from the immediate when high |
| mem_to_reg_o | output | 1 | Write-back data from memory when high |

## Verification
The in-module assertions watch every settled input on each evaluation:
- at most one match line is ever active;
- an unrecognised word never enables a write or a memory write-back;
- the memory select and the subtract code appear only with their own instruction numbers;
- each split output agrees with its field of the packed word.

The exact encodings that must be accepted or rejected can only be shown by the bench's stimulus. This covers:
- the funct7 values that tell add from subtract;
- the funct7 bits that immediate add must ignore;
- the neighbouring function codes that must be refused;
- the two fixed words from a sample program.

// File: rtl/inst_ctrl_decoder.sv
module inst_ctrl_decoder #(
  parameter int IW_W   = 32,
  parameter int NUM_W  = 3,
  parameter int CTRL_W = 6,
  parameter int N_INST = 4
) (
  input  logic [IW_W-1:0]   instr_i,
  output logic [NUM_W-1:0]  inst_num_o,
  output logic              inst_valid_o,
  output logic [CTRL_W-1:0] ctrl_word_o,
  output logic              reg_wr_o,
  output logic [2:0]        alu_op_o,
  output logic              alu_src_imm_o,
  output logic              mem_to_reg_o
);
  localparam int TBL_DEPTH = 1 << NUM_W;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [N_INST-1:0] hit;
  logic [NUM_W-1:0] num;
  logic any_hit;
  logic [CTRL_W-1:0] tbl_word;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];

  assign hit[0] = (opc == OPC_OPIMM) && (f3 == 3'b000);
  assign hit[1] = (opc == OPC_OP) && (f3 == 3'b000) && (f7 == 7'b0000000);
  assign hit[2] = (opc == OPC_OP) && (f3 == 3'b000) && (f7 == 7'b0100000);
  assign hit[3] = (opc == OPC_LOAD) && (f3 == 3'b010);

  always_comb begin
    num = '0;
    for (int k = 0; k < N_INST; k++)
      if (hit[k]) num = NUM_W'(k);
  end
  assign any_hit = |hit;

  function automatic logic [CTRL_W-1:0] table_row(input logic [NUM_W-1:0] idx);
    case (idx)
      NUM_W'(0): table_row = 6'b010001;
      NUM_W'(1): table_row = 6'b010000;
      NUM_W'(2): table_row = 6'b010010;
      NUM_W'(3): table_row = 6'b110001;
      default:   table_row = '0;
    endcase
  endfunction

  logic [CTRL_W-1:0] rom [TBL_DEPTH];
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_rom
    assign rom[g] = table_row(NUM_W'(g));
  end

  assign tbl_word     = rom[num];
  assign ctrl_word_o  = any_hit ? tbl_word : '0;
  assign inst_num_o   = num;
  assign inst_valid_o = any_hit;

  assign alu_src_imm_o = ctrl_word_o[0];
  assign alu_op_o      = ctrl_word_o[3:1];
  assign reg_wr_o      = ctrl_word_o[4];
  assign mem_to_reg_o  = ctrl_word_o[5];

  always_comb begin
    assert_one_match_R6: assert ($onehot0(hit))
      else $error("more than one match line active");
    assert_unknown_is_quiet_R5: assert (inst_valid_o || (!reg_wr_o && !mem_to_reg_o && inst_num_o == '0))
      else $error("unrecognised word drives controls");
    assert_memsel_only_load_R4: assert (!mem_to_reg_o || (inst_valid_o && inst_num_o == NUM_W'(3)))
      else $error("write-back select outside load");
    assert_sub_code_only_sub_R3: assert (alu_op_o != 3'b001 || inst_num_o == NUM_W'(2))
      else $error("subtract code outside subtract");
    assert_fields_agree_R7: assert ({mem_to_reg_o, reg_wr_o, alu_op_o, alu_src_imm_o} == ctrl_word_o)
      else $error("split fields disagree with word");
  end
endmodule

// File: tb/inst_ctrl_decoder_bench.sv
module inst_ctrl_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic [2:0]  num;
  logic        valid;
  logic [5:0]  cw;
  logic        rw, src, m2r;
  logic [2:0]  aop;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  inst_ctrl_decoder u_inst_ctrl_decoder (
    .instr_i(instr), .inst_num_o(num), .inst_valid_o(valid), .ctrl_word_o(cw),
    .reg_wr_o(rw), .alu_op_o(aop), .alu_src_imm_o(src), .mem_to_reg_o(m2r)
  );

  // expected {valid, number, control word}
  function automatic logic [9:0] model(input logic [31:0] w);
    logic [6:0] o = w[6:0];
    logic [2:0] f = w[14:12];
    logic [6:0] s = w[31:25];
    if (o == 7'b0010011 && f == 3'b000)                      return {1'b1, 3'd0, 6'b010001};
    if (o == 7'b0110011 && f == 3'b000 && s == 7'b0000000)   return {1'b1, 3'd1, 6'b010000};
    if (o == 7'b0110011 && f == 3'b000 && s == 7'b0100000)   return {1'b1, 3'd2, 6'b010010};
    if (o == 7'b0000011 && f == 3'b010)                      return {1'b1, 3'd3, 6'b110001};
    return 10'd0;
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    logic [9:0] m = model(w);
    if (!m[9]) return (w[6:0] == 7'b0110011) ? "R6" : "R5";
    case (m[8:6])
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input logic [31:0] w, input string req);
    logic [9:0] e = model(w);
    logic [9:0] a;
    @(negedge clk);
    instr = w;
    #1;
    a = {valid, num, cw};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s word=%h actual=%b expected=%b", req, w, a, e);
    end
    total++;
    if ({m2r, rw, aop, src} !== e[5:0]) begin
      bad++;
      $display("FAIL R7 word=%h actual=%b expected=%b", w, {m2r, rw, aop, src}, e[5:0]);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3, input logic [6:0] op,
                                     input logic [31:0] fill);
    return {f7, fill[24:15], f3, fill[11:7], op};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [6:0] ops [5];
    logic [6:0] f7s [4];
    void'($urandom(32'd20240611));
    ops = '{7'b0010011, 7'b0110011, 7'b0000011, 7'b0100011, 7'b1100011};
    f7s = '{7'b0000000, 7'b0100000, 7'b0000001, 7'b1111111};
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // reset/idle state: all-zero word is unrecognised (R5)
    check(32'h0000_0000, "R5");
    // sample program words (R8)
    check(32'h00B5_0633, "R8");
    check(32'h0010_0513, "R8");
    // R1: immediate add ignores upper field
    check(mk(7'b1111111, 3'b000, 7'b0010011, 32'h1234_5678), "R1");
    check(mk(7'b0100000, 3'b000, 7'b0010011, 32'h0), "R1");
    // R2 / R3
    check(mk(7'b0000000, 3'b000, 7'b0110011, 32'hFFFF_FFFF), "R2");
    check(mk(7'b0100000, 3'b000, 7'b0110011, 32'hABCD_EF01), "R3");
    // R4 load, and a load with other width code
    check(mk(7'b0000000, 3'b010, 7'b0000011, 32'h0F0F_0F0F), "R4");
    check(mk(7'b0000000, 3'b011, 7'b0000011, 32'h0), "R5");
    // R6 near misses
    check(mk(7'b0000001, 3'b000, 7'b0110011, 32'h0), "R6");
    check(mk(7'b0100001, 3'b000, 7'b0110011, 32'h0), "R6");
    check(mk(7'b0000000, 3'b001, 7'b0110011, 32'h0), "R6");
    check(mk(7'b0100000, 3'b101, 7'b0110011, 32'h0), "R6");
    check(32'hFFFF_FFFF, "R5");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w = $urandom();
      if (i % 4 != 0)
        w = mk(f7s[$urandom_range(3)], 3'($urandom_range(7)), ops[$urandom_range(4)], $urandom());
      check(w, tag_of(w));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule